// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block chooses one winner among N requesters on every clock cycle and keeps a pairwise precedence record that decides which requester wins a contest. For every unordered pair of requesters one state bit tells which of the two currently goes first. A requester wins when no other active requester goes before it. When the winner is committed, the block rewrites every pair that contains the winner so that the winner now yields to all others. The requester that has waited longest since its last service therefore always leads. The scheme suits a small number of inputs, because the state grows with the square of N.

The grant is a combinational function of the request vector and the stored precedence state, so a request is answered in the same cycle. The precedence state moves only on a clock edge where a grant is issued and the advance input is high. With advance held low, the caller can look at the grant without using it up. The block has no state machine: its only sequential state is the precedence triangle. That state has two behaviours, *hold* and *reorder on commit*, and a synchronous reset returns it to index order.

Top module: `mtx_arbiter`

## Requirements
- R1: While reset is high, and on the first cycle after it, lower index goes before higher index for every pair, so requester 0 wins whenever it requests.
- R2: At most one bit of `gnt_o` is set in any cycle, and a grant bit is set only where the same bit of `req_i` is set.
- R3: When at least one bit of `req_i` is set, exactly one grant bit is set.
- R4: The grant goes to the active requester that goes before every other active requester in the current precedence order.
- R5: On a clock edge with a grant and `adv_i` high, the granted requester becomes last against every other requester, and the relative order of the others is kept.
- R6: On a clock edge with `adv_i` low, the precedence state does not change, so the same request pattern gets the same grant again.
- R7: With `req_i` all zeros, `gnt_o` is all zeros and the precedence state does not change, whatever `adv_i` is.
- R8: With `adv_i` held high, a request held until it is served is granted within N cycles.
- R9: For three requesters in the state where 2 goes before 1 and 0, and 1 goes before 0, all three requesting with advance high are served in the order 2, 1, 0, 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N | Request vector, bit k set when requester k wants service |
| adv_i | input | 1 | Commit enable: when high, a grant issued this cycle reorders the precedence |
| gnt_o | output | N | Grant vector, at most one bit set |

## Verification
The assertions assume that `req_i` and `adv_i` are stable around the clock edge and that reset is applied from time zero. They make no assumption about which request patterns occur, so both the bench's fixed sequences and its pseudo-random phase stay inside these limits. The bench drives inputs one time unit after the rising edge and compares the grant at the falling edge. The bounded-wait property is only claimed while advance stays high, so the fairness phase keeps `adv_i` at one and holds each request until a grant clears it.

// File: rtl/mtx_arb_pkg.sv
package mtx_arb_pkg;

    // Flat index of the pair (a, b) with a < b inside the upper triangle.
    function automatic int unsigned pair_idx(
        input int unsigned n,
        input int unsigned a,
        input int unsigned b
    );
        return a * n - (a * (a + 1)) / 2 + (b - a - 1);
    endfunction

    function automatic int unsigned pair_count(input int unsigned n);
        return (n * (n - 1)) / 2;
    endfunction

endpackage

// File: rtl/mtx_prio_store.sv
module mtx_prio_store
    import mtx_arb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           upd_en,
    input  logic [N-1:0]   win,
    output logic [N*N-1:0] prio_o   // bit a*N+b set: a goes before b
);
    localparam int PAIRS = pair_count(N);

    logic [PAIRS-1:0] pair_q;
    logic [PAIRS-1:0] pair_d;

    // Next triangle: row of winner cleared, column of winner set.
    generate
        for (genvar a = 0; a < N; a++) begin : g_row
            for (genvar b = a + 1; b < N; b++) begin : g_col
                localparam int IX = pair_idx(N, a, b);
                assign pair_d[IX] = win[a] ? 1'b0 :
                                    win[b] ? 1'b1 : pair_q[IX];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '1;
        end else if (upd_en) begin
            pair_q <= pair_d;
        end
    end

    // Full matrix: upper from state, lower as complement, diagonal zero.
    generate
        for (genvar a = 0; a < N; a++) begin : g_fa
            for (genvar b = 0; b < N; b++) begin : g_fb
                if (a < b) begin : g_up
                    assign prio_o[a*N+b] = pair_q[pair_idx(N, a, b)];
                end else if (a > b) begin : g_lo
                    assign prio_o[a*N+b] = ~pair_q[pair_idx(N, b, a)];
                end else begin : g_dg
                    assign prio_o[a*N+b] = 1'b0;
                end
            end
        end
    endgenerate

    // R6 / R7: without a commit the triangle holds.
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(pair_q));

    // R5: after a commit the winner yields to all others.
    generate
        for (genvar k = 0; k < N; k++) begin : g_chk
            logic [N-1:0] col_k;
            for (genvar i = 0; i < N; i++) begin : g_ci
                if (i == k) begin : g_s
                    assign col_k[i] = 1'b1;
                end else begin : g_o
                    assign col_k[i] = prio_o[i*N+k];
                end
            end
            p_last_r5: assert property (@(posedge clk) disable iff (rst)
                (upd_en && win[k]) |=>
                    (prio_o[k*N +: N] == '0) && (col_k == '1));
        end
    endgenerate

endmodule

// File: rtl/mtx_grant_pick.sv
module mtx_grant_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]   req,
    input  logic [N*N-1:0] prio,
    output logic [N-1:0]   gnt
);
    // beaten_by[k][i]: requester i goes before requester k.
    logic [N-1:0][N-1:0] beaten_by;
    logic [N-1:0]        blocked;

    generate
        for (genvar k = 0; k < N; k++) begin : g_k
            for (genvar i = 0; i < N; i++) begin : g_i
                assign beaten_by[k][i] = prio[i*N+k];
            end
            // Any active requester ahead of k raises k's disable line.
            assign blocked[k] = |(req & beaten_by[k]);
            assign gnt[k]     = req[k] & ~blocked[k];
        end
    endgenerate

endmodule

// File: rtl/mtx_arbiter.sv
module mtx_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic         adv_i,
    output logic [N-1:0] gnt_o
);
    logic [N*N-1:0] prio;
    logic [N-1:0]   gnt;
    logic           commit;

    assign commit = adv_i & (|gnt);
    assign gnt_o  = gnt;

    mtx_prio_store #(.N(N)) u_store (
        .clk    (clk),
        .rst    (rst),
        .upd_en (commit),
        .win    (gnt),
        .prio_o (prio)
    );

    mtx_grant_pick #(.N(N)) u_pick (
        .req  (req_i),
        .prio (prio),
        .gnt  (gnt)
    );

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_o));

    p_subset_r2: assert property (@(posedge clk) disable iff (rst)
        (gnt_o & ~req_i) == '0);

    p_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (|req_i) |-> ($countones(gnt_o) == 1));

    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |-> (gnt_o == '0));

    // R1: the cycle after reset, requester 0 leads.
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && req_i[0]) |-> gnt_o[0]);

endmodule

// File: tb/tb_mtx_arbiter.sv
module tb_mtx_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req_i = '0;
    logic         adv_i = 1'b0;
    logic [N-1:0] gnt_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit fair_on  = 1'b0;
    bit done     = 1'b0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];
    int           ord[N];
    int           wcnt[N];

    always #2 clk = ~clk;   // 250 MHz

    mtx_arbiter #(.N(N)) dut (
        .clk(clk), .rst(rst), .req_i(req_i), .adv_i(adv_i), .gnt_o(gnt_o)
    );

    task automatic model_reset();
        for (int i = 0; i < N; i++) ord[i] = i;
    endtask

    function automatic logic [N-1:0] model_pick(input logic [N-1:0] r);
        for (int p = 0; p < N; p++)
            if (r[ord[p]]) return (N)'(1) << ord[p];
        return '0;
    endfunction

    task automatic model_commit(input logic [N-1:0] g);
        int pos = -1;
        int w;
        for (int p = 0; p < N; p++) if (g[ord[p]]) pos = p;
        if (pos < 0) return;
        w = ord[pos];
        for (int p = pos; p < N - 1; p++) ord[p] = ord[p+1];
        ord[N-1] = w;
    endtask

    // Driver: apply inputs, push expected grant.
    task automatic step(input logic [N-1:0] r, input logic a, input string tag,
                        output logic [N-1:0] e);
        @(posedge clk);
        #1;
        req_i = r;
        adv_i = a;
        e = model_pick(r);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (a && !rst) model_commit(e);
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst = 1'b1; req_i = '0; adv_i = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
        model_reset();
    endtask

    // Monitor: compare at falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (gnt_o !== e) begin
                n_fails++;
                $display("FAIL %s: gnt actual %b expected %b (req %b)", t, gnt_o, e, req_i);
            end
        end
        if (fair_on) begin
            n_checks++;
            for (int i = 0; i < N; i++) begin
                if (req_i[i] && !gnt_o[i]) wcnt[i]++;
                else wcnt[i] = 0;
                if (wcnt[i] >= N) begin
                    n_fails++;
                    $display("FAIL R8: requester %0d wait actual %0d expected < %0d", i, wcnt[i], N);
                    wcnt[i] = 0;
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_fails++;
        $display("FAIL watchdog: run actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [N-1:0] e;
        logic [N-1:0] held;
        model_reset();
        for (int i = 0; i < N; i++) wcnt[i] = 0;

        // R1: during reset, index order; adv has no effect.
        step(4'b1111, 1'b1, "R1", e);
        step(4'b1110, 1'b1, "R1", e);
        step(4'b0000, 1'b0, "R7", e);
        @(posedge clk); #1; rst = 1'b0;
        step(4'b1111, 1'b0, "R1", e);

        // R6: advance low keeps the same winner.
        step(4'b1111, 1'b0, "R6", e);
        step(4'b1111, 1'b0, "R6", e);

        // R5: rotation with everyone requesting.
        for (int i = 0; i < 5; i++) step(4'b1111, 1'b1, "R5", e);

        // R7: idle cycles with advance high leave order untouched.
        for (int i = 0; i < 3; i++) step(4'b0000, 1'b1, "R7", e);
        step(4'b1111, 1'b0, "R7", e);

        // R4: partial request patterns.
        step(4'b1010, 1'b1, "R4", e);
        step(4'b0110, 1'b1, "R4", e);
        step(4'b1001, 1'b1, "R4", e);
        step(4'b0101, 1'b0, "R4", e);
        step(4'b1100, 1'b1, "R4", e);
        step(4'b0011, 1'b1, "R4", e);

        // R9: reach 2 > 1 > 0, then serve 2,1,0,2.
        do_reset();
        step(4'b0001, 1'b1, "R9", e);
        step(4'b0010, 1'b1, "R9", e);
        step(4'b0001, 1'b1, "R9", e);
        step(4'b0111, 1'b1, "R9", e);
        step(4'b0111, 1'b1, "R9", e);
        step(4'b0111, 1'b1, "R9", e);
        step(4'b0111, 1'b1, "R9", e);

        // R2 / R3: pseudo-random requests and advance.
        for (int i = 0; i < 300; i++)
            step((N)'($urandom), 1'($urandom), "R2", e);

        // R8: held requests with advance high.
        held = '0;
        step('0, 1'b1, "R8", e);
        fair_on = 1'b1;
        for (int i = 0; i < 400; i++) begin
            logic [N-1:0] r;
            r = held | (N)'($urandom);
            step(r, 1'b1, "R8", e);
            held = r & ~e;
        end
        @(posedge clk); #1;
        fair_on = 1'b0;
        req_i = '0;

        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule